// File: doc/BRIEF.md
# Program-Memory Table Transfer Unit

This block keeps the pointer and the word-wide holding register that the table read and table write instructions use to move data between program memory and the byte-wide register file. The datapath sends it one command per instruction: a direction, a byte-select bit, a post-increment bit and a data byte. The unit steps through a fixed two-cycle transfer with a synchronous program-memory port. The pointer drives the memory address at all times. On a read, the unit returns one byte of the fetched word and keeps the whole word. On a write, it merges the new byte into the stored word and writes the full word out.

The pointer can also be loaded one byte at a time through a separate load port, so software can aim it anywhere in the 64K-word space. The memory array and the instruction decoder are outside the block.

Top module: `tblxfer_unit`

## Requirements
- R1: After synchronous reset the pointer and the holding word are zero: `mem_addr` reads 0000h, `busy`, `rd_valid`, `mem_rd_en` and `mem_wr_en` are low, and a first write that updates only the high byte sends a word whose low byte is 00h.
- R2: A read command accepted in an idle cycle raises `mem_rd_en` in that cycle. In the next cycle `rd_valid` is high and `rd_byte` is bits [7:0] of the memory word when `cmd_hi`=0, or bits [15:8] when `cmd_hi`=1.
- R3: A write command accepted in an idle cycle puts `cmd_data` into the selected byte of the holding word (`cmd_hi`=0 low, 1 high). In the next cycle `mem_wr_en` is high, `mem_addr` is the unchanged pointer, and `mem_wdata` carries the whole updated word.
- R4: With `cmd_inc`=1 the pointer advances by one at the end of the second transfer cycle, after the memory access has used the old value. With `cmd_inc`=0 it does not change.
- R5: Incrementing the pointer from FFFFh gives 0000h.
- R6: While `busy` is high (the second transfer cycle), `cmd_valid` is ignored: it starts no memory access and does not change the holding word.
- R7: A pointer load (`ptr_ld_en`) replaces the high byte (`ptr_ld_hi`=1, bits [15:8]) or the low byte (`ptr_ld_hi`=0, bits [7:0]), visible on `mem_addr` in the next cycle. It is ignored in a cycle where a command is accepted or `busy` is high.
- R8: A read stores the full fetched word in the holding register, so a following write to one byte sends the other byte exactly as it was read.
- R9: Every accepted command holds `busy` for exactly one cycle, and a new command can be accepted in the cycle right after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request for this cycle |
| cmd_write | input | 1 | 1 = table write, 0 = table read |
| cmd_hi | input | 1 | Byte select: 1 = high byte, 0 = low byte |
| cmd_inc | input | 1 | Post-increment the pointer |
| cmd_data | input | 8 | Byte from the register file for writes |
| ptr_ld_en | input | 1 | Load one pointer byte |
| ptr_ld_hi | input | 1 | Pointer byte to load: 1 = high, 0 = low |
| ptr_ld_data | input | 8 | Pointer load value |
| mem_addr | output | 16 | Program-memory address (the pointer) |
| mem_rd_en | output | 1 | Memory read strobe; data returns next cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Word to write |
| mem_rdata | input | 16 | Word read, one cycle after `mem_rd_en` |
| rd_valid | output | 1 | `rd_byte` holds read data |
| rd_byte | output | 8 | Selected byte of the fetched word |
| busy | output | 1 | Second transfer cycle in progress |

## Verification
The hardest case is a command or pointer load arriving while a transfer is already running, because the second cycle lasts only one clock. The bench holds `cmd_valid` high, with a write of a distinctive byte, and `ptr_ld_en` high through the busy cycle of a read. It then shows at the ports that nothing leaked: no write strobe, an unchanged address, and a later single-byte write that still carries the word read earlier. Pointer wraparound is reached by loading FFFFh through the byte-load port and then issuing incrementing reads and writes.

// File: rtl/tblxfer_pkg.sv
package tblxfer_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } xfer_state_e;

    typedef struct packed {
        logic write;
        logic hi;
        logic inc;
    } xfer_op_t;

    function automatic byte_t pick_byte(input word_t w, input logic hi);
        return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    endfunction

    function automatic word_t merge_byte(input word_t w, input logic hi, input byte_t b);
        word_t r;
        r = w;
        if (hi) r[WORD_W-1:BYTE_W] = b;
        else    r[BYTE_W-1:0]      = b;
        return r;
    endfunction

endpackage

// File: rtl/tblxfer_pointer.sv
module tblxfer_pointer
    import tblxfer_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic              ld_hi,
    input  byte_t             ld_data,
    input  logic              inc_en,
    output logic [ADDR_W-1:0] ptr
);
    localparam int HI_W = ADDR_W - BYTE_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (inc_en) begin
            ptr <= ptr + ADDR_W'(1);
        end else if (ld_en) begin
            if (ld_hi) ptr[ADDR_W-1:BYTE_W] <= HI_W'(ld_data);
            else       ptr[BYTE_W-1:0]      <= ld_data;
        end
    end

    assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!inc_en && !ld_en) |=> $stable(ptr));

    assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (inc_en && (&ptr)) |=> (ptr == '0));

endmodule

// File: rtl/tblxfer_latch.sv
module tblxfer_latch
    import tblxfer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  byte_we,
    input  logic  byte_hi,
    input  byte_t byte_in,
    input  logic  word_we,
    input  word_t word_in,
    output word_t word_out
);
    always_ff @(posedge clk) begin
        if (rst)          word_out <= '0;
        else if (word_we) word_out <= word_in;
        else if (byte_we) word_out <= merge_byte(word_out, byte_hi, byte_in);
    end

    assert_latch_word_R8: assert property (@(posedge clk) disable iff (rst)
        word_we |=> (word_out == $past(word_in)));

    assert_latch_keep_low_R3: assert property (@(posedge clk) disable iff (rst)
        (byte_we && byte_hi && !word_we) |=>
            (word_out[BYTE_W-1:0] == $past(word_out[BYTE_W-1:0])));

    assert_latch_keep_high_R3: assert property (@(posedge clk) disable iff (rst)
        (byte_we && !byte_hi && !word_we) |=>
            (word_out[WORD_W-1:BYTE_W] == $past(word_out[WORD_W-1:BYTE_W])));

endmodule

// File: rtl/tblxfer_seq.sv
module tblxfer_seq
    import tblxfer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  xfer_op_t    cmd_op,
    output logic        accept,
    output xfer_state_e state,
    output xfer_op_t    op_q
);
    assign accept = (state == ST_IDLE) && cmd_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            op_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state <= ST_XFER;
                    op_q  <= cmd_op;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_seq_single_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_XFER) |=> (state == ST_IDLE));

    assert_seq_enter_R9: assert property (@(posedge clk) disable iff (rst)
        accept |=> (state == ST_XFER));

endmodule

// File: rtl/tblxfer_unit.sv
module tblxfer_unit
    import tblxfer_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic              cmd_hi,
    input  logic              cmd_inc,
    input  logic [7:0]        cmd_data,
    input  logic              ptr_ld_en,
    input  logic              ptr_ld_hi,
    input  logic [7:0]        ptr_ld_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    output logic              rd_valid,
    output logic [7:0]        rd_byte,
    output logic              busy
);
    xfer_op_t    cmd_op;
    xfer_op_t    op_q;
    xfer_state_e state;
    logic        accept;
    logic        in_xfer;
    logic        ptr_load_ok;
    word_t       latch_word;

    assign cmd_op = '{write: cmd_write, hi: cmd_hi, inc: cmd_inc};

    tblxfer_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .accept    (accept),
        .state     (state),
        .op_q      (op_q)
    );

    assign in_xfer     = (state == ST_XFER);
    assign ptr_load_ok = ptr_ld_en && !in_xfer && !accept;

    tblxfer_pointer #(.ADDR_W(ADDR_W)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ptr_load_ok),
        .ld_hi   (ptr_ld_hi),
        .ld_data (ptr_ld_data),
        .inc_en  (in_xfer && op_q.inc),
        .ptr     (mem_addr)
    );

    tblxfer_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .byte_we  (accept && cmd_write),
        .byte_hi  (cmd_hi),
        .byte_in  (cmd_data),
        .word_we  (rd_valid),
        .word_in  (mem_rdata),
        .word_out (latch_word)
    );

    assign mem_rd_en = accept && !cmd_write;
    assign mem_wr_en = in_xfer && op_q.write;
    assign mem_wdata = latch_word;
    assign rd_valid  = in_xfer && !op_q.write;
    assign rd_byte   = pick_byte(mem_rdata, op_q.hi);
    assign busy      = in_xfer;

    assert_wr_follows_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> $past(cmd_valid && cmd_write && !busy));

    assert_rd_follows_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> rd_valid);

    assert_no_start_when_busy_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !mem_rd_en);

    assert_busy_single_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    assert_addr_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !op_q.inc) |=> $stable(mem_addr));

    assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));

endmodule

// File: tb/tblxfer_unit_bench.sv
module tblxfer_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_hi = 1'b0, cmd_inc = 1'b0;
    logic [7:0]  cmd_data = '0;
    logic        ptr_ld_en = 1'b0, ptr_ld_hi = 1'b0;
    logic [7:0]  ptr_ld_data = '0;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_rd_en, mem_wr_en, rd_valid, busy;
    logic [7:0]  rd_byte;

    int checks = 0;
    int errors = 0;

    logic [15:0] mem [256];
    logic [15:0] exp_ptr = '0;
    logic [15:0] exp_latch = '0;

    always #2.5 clk = ~clk;

    tblxfer_unit u_tblxfer_unit (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_hi(cmd_hi),
        .cmd_inc(cmd_inc), .cmd_data(cmd_data),
        .ptr_ld_en(ptr_ld_en), .ptr_ld_hi(ptr_ld_hi), .ptr_ld_data(ptr_ld_data),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rd_valid(rd_valid), .rd_byte(rd_byte), .busy(busy)
    );

    initial begin
        for (int i = 0; i < 256; i++)
            mem[i] = {8'(i) ^ 8'hA5, 8'(i * 3 + 1)};
    end

    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sel(input logic [15:0] w, input logic hi);
        return hi ? w[15:8] : w[7:0];
    endfunction

    task automatic load_ptr(input logic hi, input logic [7:0] val);
        ptr_ld_en = 1'b1; ptr_ld_hi = hi; ptr_ld_data = val;
        if (hi) exp_ptr[15:8] = val; else exp_ptr[7:0] = val;
        @(negedge clk);
        ptr_ld_en = 1'b0;
        #1;
        check(mem_addr == exp_ptr, "R7 pointer load", mem_addr, exp_ptr);
    endtask

    task automatic do_read(input logic hi, input logic inc);
        logic [15:0] word;
        word = mem[exp_ptr[7:0]];
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_hi = hi; cmd_inc = inc;
        #1;
        check(mem_rd_en == 1'b1, "R2/R9 read strobe on accept", mem_rd_en, 1);
        check(mem_addr == exp_ptr, "R4 read uses old pointer", mem_addr, exp_ptr);
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        check(rd_valid && busy, "R2 rd_valid with busy", {rd_valid, busy}, 2'b11);
        check(rd_byte == sel(word, hi), "R2 read byte", rd_byte, sel(word, hi));
        exp_latch = word;
        if (inc) exp_ptr = exp_ptr + 16'd1;
        @(negedge clk);
        #1;
        check(mem_addr == exp_ptr && !busy, "R4/R5 pointer after read", mem_addr, exp_ptr);
    endtask

    task automatic do_write(input logic hi, input logic inc, input logic [7:0] data);
        cmd_valid = 1'b1; cmd_write = 1'b1; cmd_hi = hi; cmd_inc = inc; cmd_data = data;
        if (hi) exp_latch[15:8] = data; else exp_latch[7:0] = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        check(mem_wr_en == 1'b1, "R3 write strobe", mem_wr_en, 1);
        check(mem_wdata == exp_latch, "R3/R8 write word", mem_wdata, exp_latch);
        check(mem_addr == exp_ptr, "R3 write address", mem_addr, exp_ptr);
        if (inc) exp_ptr = exp_ptr + 16'd1;
        @(negedge clk);
        #1;
        check(mem_addr == exp_ptr && !mem_wr_en, "R4/R5 pointer after write", mem_addr, exp_ptr);
    endtask

    task automatic test_reset();
        check(mem_addr == 16'h0000, "R1 reset pointer", mem_addr, 0);
        check(!busy && !rd_valid && !mem_rd_en && !mem_wr_en, "R1 reset idle",
              {busy, rd_valid, mem_rd_en, mem_wr_en}, 0);
        do_write(1'b1, 1'b0, 8'h3C);   // R1: low byte must still be 00h
        check(mem_wdata[7:0] == 8'h00, "R1 latch cleared", mem_wdata[7:0], 0);
    endtask

    task automatic test_read_modes();
        load_ptr(1'b1, 8'h00);
        load_ptr(1'b0, 8'h10);
        do_read(1'b0, 1'b0);           // R4 no increment
        do_read(1'b1, 1'b1);           // R2 high byte, R4 increment
        do_read(1'b0, 1'b1);
    endtask

    task automatic test_read_then_write();
        load_ptr(1'b0, 8'h20);
        do_read(1'b1, 1'b0);           // R8: holds whole word of 0x20
        do_write(1'b0, 1'b1, 8'h5A);   // high byte must be the read one
        do_write(1'b1, 1'b0, 8'hC3);   // lands at 0x21
        load_ptr(1'b0, 8'h20);
        do_read(1'b0, 1'b1);
        check(exp_latch[7:0] == 8'h5A, "R3 memory took merged word", exp_latch[7:0], 8'h5A);
        do_read(1'b1, 1'b0);
        check(rd_byte == 8'hC3 || exp_latch[15:8] == 8'hC3, "R3 second write stored",
              exp_latch[15:8], 8'hC3);
    endtask

    task automatic test_wrap();
        load_ptr(1'b1, 8'hFF);
        load_ptr(1'b0, 8'hFF);
        do_read(1'b0, 1'b1);           // R5 wraps to 0000h
        check(mem_addr == 16'h0000, "R5 wrap on read", mem_addr, 0);
        load_ptr(1'b1, 8'hFF);
        load_ptr(1'b0, 8'hFF);
        do_write(1'b1, 1'b1, 8'h77);
        check(mem_addr == 16'h0000, "R5 wrap on write", mem_addr, 0);
    endtask

    task automatic test_busy_ignore();
        logic [15:0] word;
        load_ptr(1'b1, 8'h00);
        load_ptr(1'b0, 8'h40);
        word = mem[8'h40];
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_hi = 1'b0; cmd_inc = 1'b0;
        ptr_ld_en = 1'b1; ptr_ld_hi = 1'b0; ptr_ld_data = 8'h99;   // R7 during accept
        @(negedge clk);
        cmd_write = 1'b1; cmd_data = 8'hEE;                         // R6 held during busy
        #1;
        check(busy == 1'b1, "R6 busy in second cycle", busy, 1);
        check(!mem_rd_en, "R6 no new read while busy", mem_rd_en, 0);
        @(negedge clk);
        cmd_valid = 1'b0; ptr_ld_en = 1'b0;
        #1;
        check(!mem_wr_en && !busy, "R6 held command dropped", {mem_wr_en, busy}, 0);
        check(mem_addr == 16'h0040, "R7 load ignored in accept/busy", mem_addr, 16'h0040);
        exp_latch = word;
        do_write(1'b1, 1'b0, 8'h12);
        check(mem_wdata[7:0] == word[7:0], "R6 latch untouched by ignored write",
              mem_wdata[7:0], word[7:0]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        test_reset();
        test_read_modes();
        test_read_then_write();
        test_wrap();
        test_busy_ignore();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule